// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the combinational arithmetic and logic unit of a small RISC core. One operation code picks among add and subtract (with or without the incoming carry), bitwise AND, OR and XOR, one's and two's complement, increment, decrement, left and right shifts, rotates through carry, nibble swap and two compare forms. The first operand always comes from the destination register. The second operand comes either from a source register or from an immediate field.

For every operation the block returns the result and a write enable for it. It also returns the full next status vector and a mask that shows which flags the operation is allowed to change. Flags outside the mask pass through from the incoming flags unchanged, so the core can load the returned vector directly. The register file, the multiplier and the branch logic sit outside.

Top module: `alu8_core`

## Requirements
- R1: Flag vectors use bit 5 = H, bit 4 = S, bit 3 = V, bit 2 = N, bit 1 = Z, bit 0 = C, for flags_in, flags_out and flags_mask alike. A flag whose mask bit is 0 leaves flags_out equal to flags_in.
- R2: Addition (code 0) and addition with carry (code 1, adds flags_in C) give the 8-bit sum and update all six flags. C is the carry out of bit 7, H is the carry out of bit 3, and V is two's-complement overflow.
- R3: Subtraction (code 2) and subtraction with carry (code 3, also subtracts flags_in C) give the 8-bit difference and update all six flags. C is the borrow out of bit 7 and H is the borrow out of bit 3. For code 3, Z is set only if the difference is zero and flags_in Z was already set.
- R4: AND (code 4), OR (code 5) and XOR (code 6) update S, V, N and Z with V forced to 0. They leave C and H unchanged.
- R5: One's complement (code 7) returns 0xFF minus the first operand, sets C to 1, clears V, updates S, N and Z, and leaves H unchanged.
- R6: Two's complement (code 8) returns 0x00 minus the first operand and updates all six flags. C is 1 unless the result is zero, V is 1 only for the result 0x80, and H is the borrow out of bit 3.
- R7: Increment (code 9) and decrement (code 10) update S, V, N and Z and leave C and H unchanged. V is set only when increment goes from 0x7F to 0x80 or decrement goes from 0x80 to 0x7F.
- R8: Logical left (code 11), logical right (code 12), rotate left through carry (code 13), rotate right through carry (code 14) and arithmetic right (code 15) give the shifted value. C receives the bit shifted out. Logical shifts fill with 0, rotates fill with flags_in C, and the arithmetic shift keeps bit 7. V equals N XOR C, S, N and Z are updated, and H is unchanged.
- R9: Nibble swap (code 16) exchanges bits 7..4 with bits 3..0 and changes no flag.
- R10: Compare (code 17) and compare with carry (code 18) set flags exactly as codes 2 and 3 do, and hold result_we at 0.
- R11: Whenever S is updated it equals N XOR V of the new flags.
- R12: The second operand is imm_val when use_imm is 1 and rr_val otherwise.
- R13: Codes 19 to 31 hold result_we and flags_mask at 0, so flags_out equals flags_in. Every defined code other than 17 and 18 drives result_we to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 5 | Operation select |
| rd_val | input | 8 | First operand (destination register value) |
| rr_val | input | 8 | Source register operand |
| imm_val | input | 8 | Immediate operand |
| use_imm | input | 1 | Take the immediate as the second operand |
| flags_in | input | 6 | Current status flags {H,S,V,N,Z,C} |
| result | output | 8 | Operation result |
| result_we | output | 1 | Result should be written back |
| flags_out | output | 6 | Next status flags, masked merge with flags_in |
| flags_mask | output | 6 | Flags the operation updates |

## Verification
The immediate assertions are evaluated after the combinational logic has settled. They assume every input carries a known 0 or 1 value, with no X or Z bits. They also assume op_code values above 18 are legal and mean "no operation" rather than being excluded. The stimulus respects both assumptions: all operands, flags and the use_imm bit are drawn as fully defined values from a seeded generator, and op_code is drawn from the whole 5-bit range so that undefined codes appear alongside the defined ones. Directed vectors add the overflow edges 0x7F and 0x80, zero results, sticky-zero chains and carry-in rotations.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_COM  = 5'd7,
        OP_NEG  = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_LSL  = 5'd11,
        OP_LSR  = 5'd12,
        OP_ROL  = 5'd13,
        OP_ROR  = 5'd14,
        OP_ASR  = 5'd15,
        OP_SWAP = 5'd16,
        OP_CMP  = 5'd17,
        OP_CMPC = 5'd18
    } alu_op_e;

    // bit 5 .. bit 0 = H S V N Z C
    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

    localparam logic [5:0] FMASK_ALL   = 6'b111111;
    localparam logic [5:0] FMASK_SVNZC = 6'b011111;
    localparam logic [5:0] FMASK_SVNZ  = 6'b011110;

    function automatic logic uses_adder(input logic [4:0] code);
        case (code)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG,
            OP_INC, OP_DEC, OP_CMP, OP_CMPC: return 1'b1;
            default:                         return 1'b0;
        endcase
    endfunction

    function automatic logic is_shift(input logic [4:0] code);
        case (code)
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: return 1'b1;
            default:                                return 1'b0;
        endcase
    endfunction

    function automatic logic [5:0] mask_for(input logic [4:0] code);
        case (code)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC,
            OP_NEG, OP_CMP, OP_CMPC:             return FMASK_ALL;
            OP_COM, OP_LSL, OP_LSR, OP_ROL,
            OP_ROR, OP_ASR:                      return FMASK_SVNZC;
            OP_AND, OP_OR, OP_XOR, OP_INC,
            OP_DEC:                              return FMASK_SVNZ;
            default:                             return 6'b000000;
        endcase
    endfunction

    function automatic logic writes_result(input logic [4:0] code);
        return (code <= OP_SWAP);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          carry_in,
    input  logic          do_sub,
    output logic [DW-1:0] sum,
    output logic          carry_out,
    output logic          half_out,
    output logic          ovf_out
);
    localparam int NIB = DW / 2;

    logic [DW-1:0]  opb_x;
    logic           cin_x;
    logic [DW:0]    wide;
    logic [NIB:0]   low;

    // Subtraction as a + ~b + ~borrow; carries are inverted back into borrows.
    assign opb_x = do_sub ? ~opb : opb;
    assign cin_x = do_sub ? ~carry_in : carry_in;
    assign wide  = {1'b0, opa} + {1'b0, opb_x} + {{DW{1'b0}}, cin_x};
    assign low   = {1'b0, opa[NIB-1:0]} + {1'b0, opb_x[NIB-1:0]} + {{NIB{1'b0}}, cin_x};

    assign sum       = wide[DW-1:0];
    assign carry_out = wide[DW] ^ do_sub;
    assign half_out  = low[NIB] ^ do_sub;
    assign ovf_out   = (opa[DW-1] == opb_x[DW-1]) && (sum[DW-1] != opa[DW-1]);

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [4:0]    op_code,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          carry_in,
    output logic [DW-1:0] res,
    output logic          carry_out
);
    localparam int NIB = DW / 2;

    always_comb begin
        res       = opa;
        carry_out = carry_in;
        case (op_code)
            OP_AND:  res = opa & opb;
            OP_OR:   res = opa | opb;
            OP_XOR:  res = opa ^ opb;
            OP_COM: begin
                res       = ~opa;
                carry_out = 1'b1;
            end
            OP_LSL: begin
                res       = {opa[DW-2:0], 1'b0};
                carry_out = opa[DW-1];
            end
            OP_ROL: begin
                res       = {opa[DW-2:0], carry_in};
                carry_out = opa[DW-1];
            end
            OP_LSR: begin
                res       = {1'b0, opa[DW-1:1]};
                carry_out = opa[0];
            end
            OP_ROR: begin
                res       = {carry_in, opa[DW-1:1]};
                carry_out = opa[0];
            end
            OP_ASR: begin
                res       = {opa[DW-1], opa[DW-1:1]};
                carry_out = opa[0];
            end
            OP_SWAP: res = {opa[NIB-1:0], opa[DW-1:NIB]};
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [4:0]    op_code,
    input  logic [DW-1:0] rd_val,
    input  logic [DW-1:0] rr_val,
    input  logic [DW-1:0] imm_val,
    input  logic          use_imm,
    input  logic [5:0]    flags_in,
    output logic [DW-1:0] result,
    output logic          result_we,
    output logic [5:0]    flags_out,
    output logic [5:0]    flags_mask
);
    flags_t        fin;
    flags_t        fnew;
    logic [DW-1:0] opnd_b;

    logic [DW-1:0] as_a, as_b, as_sum;
    logic          as_cin, as_sub, as_c, as_h, as_v;
    logic [DW-1:0] bo_res;
    logic          bo_c;
    logic          zero_sticky;

    assign fin    = flags_t'(flags_in);
    assign opnd_b = use_imm ? imm_val : rr_val;

    // Operand routing for the shared adder
    always_comb begin
        as_a   = rd_val;
        as_b   = opnd_b;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op_code)
            OP_ADC:          as_cin = fin.c;
            OP_SUB, OP_CMP:  as_sub = 1'b1;
            OP_SBC, OP_CMPC: begin
                as_sub = 1'b1;
                as_cin = fin.c;
            end
            OP_NEG: begin
                as_a   = '0;
                as_b   = rd_val;
                as_sub = 1'b1;
            end
            OP_INC:  as_b = DW'(1);
            OP_DEC: begin
                as_b   = DW'(1);
                as_sub = 1'b1;
            end
            default: ;
        endcase
    end

    alu8_addsub #(.DW(DW)) u_addsub (
        .opa       (as_a),
        .opb       (as_b),
        .carry_in  (as_cin),
        .do_sub    (as_sub),
        .sum       (as_sum),
        .carry_out (as_c),
        .half_out  (as_h),
        .ovf_out   (as_v)
    );

    alu8_bitops #(.DW(DW)) u_bitops (
        .op_code   (op_code),
        .opa       (rd_val),
        .opb       (opnd_b),
        .carry_in  (fin.c),
        .res       (bo_res),
        .carry_out (bo_c)
    );

    assign zero_sticky = (op_code == OP_SBC) || (op_code == OP_CMPC);
    assign result      = uses_adder(op_code) ? as_sum : bo_res;

    always_comb begin
        fnew.h = as_h;
        fnew.c = uses_adder(op_code) ? as_c : bo_c;
        fnew.n = result[DW-1];
        fnew.z = (result == '0) && (!zero_sticky || fin.z);
        if (uses_adder(op_code))
            fnew.v = as_v;
        else if (is_shift(op_code))
            fnew.v = fnew.n ^ fnew.c;
        else
            fnew.v = 1'b0;
        fnew.s = fnew.n ^ fnew.v;
    end

    assign flags_mask = mask_for(op_code);
    assign flags_out  = (fnew & flags_mask) | (flags_in & ~flags_mask);
    assign result_we  = writes_result(op_code) && (op_code != OP_CMP) && (op_code != OP_CMPC);

    // Checks on the settled outputs
    always_comb begin
        if (op_code == OP_SWAP) begin
            AST_SWAP_KEEPS_FLAGS: assert (flags_out == flags_in); // R9
        end
        if (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR) begin
            AST_LOGIC_CLEARS_V: assert (!flags_out[3] && flags_out[0] == flags_in[0]); // R4
        end
        if (op_code == OP_INC || op_code == OP_DEC) begin
            AST_STEP_KEEPS_CARRY: assert (flags_out[0] == flags_in[0] && flags_out[5] == flags_in[5]); // R7
        end
        if ((op_code == OP_SBC || op_code == OP_CMPC) && !flags_in[1]) begin
            AST_STICKY_ZERO: assert (!flags_out[1]); // R3
        end
        if (op_code == OP_CMP || op_code == OP_CMPC) begin
            AST_COMPARE_NO_WRITE: assert (!result_we); // R10
        end
        if (op_code == OP_COM) begin
            AST_COM_CARRY_SET: assert (flags_out[0] && !flags_out[3]); // R5
        end
        if (flags_mask[4]) begin
            AST_SIGN_RULE: assert (flags_out[4] == (flags_out[2] ^ flags_out[3])); // R11
        end
        if (op_code > OP_CMPC) begin
            AST_UNDEF_INERT: assert (!result_we && flags_out == flags_in); // R13
        end
    end

endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op_code;
    logic [7:0] rd_val, rr_val, imm_val;
    logic       use_imm;
    logic [5:0] flags_in;
    logic [7:0] result;
    logic       result_we;
    logic [5:0] flags_out, flags_mask;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    alu8_core u_alu8_core (
        .op_code    (op_code),
        .rd_val     (rd_val),
        .rr_val     (rr_val),
        .imm_val    (imm_val),
        .use_imm    (use_imm),
        .flags_in   (flags_in),
        .result     (result),
        .result_we  (result_we),
        .flags_out  (flags_out),
        .flags_mask (flags_mask)
    );

    function automatic int sx(input int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0, 1:                 return "R2";
            2, 3:                 return "R3";
            4, 5, 6:              return "R4";
            7:                    return "R5";
            8:                    return "R6";
            9, 10:                return "R7";
            11, 12, 13, 14, 15:   return "R8";
            16:                   return "R9";
            17, 18:               return "R10";
            default:              return "R13";
        endcase
    endfunction

    // Returns {result[7:0], we, mask[5:0], flags[5:0]}
    function automatic logic [20:0] model(input int op, input int a, input int b, input logic [5:0] fi);
        int   r, full, cc, sr;
        logic we, h, v, c, n, z, s, stick;
        logic [5:0] m, fnew;
        r = a; we = 1'b1; m = 6'h00; stick = 1'b0;
        h = fi[5]; v = fi[3]; c = fi[0];
        case (op)
            0, 1: begin
                cc = (op == 1) ? int'(fi[0]) : 0;
                full = a + b + cc; r = full % 256; c = full > 255;
                h = ((a % 16) + (b % 16) + cc) > 15;
                sr = sx(a) + sx(b) + cc; v = (sr > 127) || (sr < -128);
                m = 6'h3F;
            end
            2, 3, 17, 18: begin
                cc = (op == 3 || op == 18) ? int'(fi[0]) : 0;
                full = a - b - cc; r = (full + 512) % 256; c = full < 0;
                h = ((a % 16) - (b % 16) - cc) < 0;
                sr = sx(a) - sx(b) - cc; v = (sr > 127) || (sr < -128);
                m = 6'h3F; we = (op < 17); stick = (op == 3 || op == 18);
            end
            4: begin r = a & b; v = 1'b0; m = 6'h1E; end
            5: begin r = a | b; v = 1'b0; m = 6'h1E; end
            6: begin r = a ^ b; v = 1'b0; m = 6'h1E; end
            7: begin r = 255 - a; c = 1'b1; v = 1'b0; m = 6'h1F; end
            8: begin
                r = (256 - a) % 256; c = (a != 0); h = (a % 16) != 0;
                v = (a == 128); m = 6'h3F;
            end
            9:  begin r = (a + 1) % 256;   v = (a == 127); m = 6'h1E; end
            10: begin r = (a + 255) % 256; v = (a == 128); m = 6'h1E; end
            11: begin r = (a * 2) % 256;              c = a >= 128; m = 6'h1F; end
            12: begin r = a / 2;                      c = a % 2;    m = 6'h1F; end
            13: begin r = (a * 2) % 256 + int'(fi[0]); c = a >= 128; m = 6'h1F; end
            14: begin r = a / 2 + 128 * int'(fi[0]);  c = a % 2;    m = 6'h1F; end
            15: begin r = a / 2 + ((a >= 128) ? 128 : 0); c = a % 2; m = 6'h1F; end
            16: begin r = (a % 16) * 16 + a / 16; m = 6'h00; end
            default: begin we = 1'b0; m = 6'h00; end
        endcase
        n = r >= 128;
        if (op >= 11 && op <= 15) v = n ^ c;
        z = (r == 0) && (!stick || fi[1]);
        s = n ^ v;
        fnew = {h, s, v, n, z, c};
        return {8'(r), we, m, (fnew & m) | (fi & ~m)};
    endfunction

    task automatic run_vec(input int op, input int a, input int rr, input int im,
                           input logic ui, input logic [5:0] fi);
        logic [20:0] exp;
        int          b;
        logic        bad;
        @(posedge clk);
        op_code = 5'(op); rd_val = 8'(a); rr_val = 8'(rr); imm_val = 8'(im);
        use_imm = ui; flags_in = fi;
        b   = ui ? im : rr; // R12 operand select
        exp = model(op, a, b, fi);
        @(negedge clk);
        n_chk++;
        bad = (result_we != exp[12]) || (flags_mask != exp[11:6]) || (flags_out != exp[5:0])
              || (exp[12] && result != exp[20:13]);
        if (bad) begin
            n_fail++;
            $display("FAIL %s (R1 flags) op=%0d a=%02h b=%02h fi=%06b: got res=%02h we=%0b mask=%06b flags=%06b, exp res=%02h we=%0b mask=%06b flags=%06b",
                     tag_of(op), op, a, b, fi, result, result_we, flags_mask, flags_out,
                     exp[20:13], exp[12], exp[11:6], exp[5:0]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        op_code = '0; rd_val = '0; rr_val = '0; imm_val = '0; use_imm = 1'b0; flags_in = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle vector right after reset: 0 + 0
        run_vec(0, 8'h00, 8'h00, 8'h00, 1'b0, 6'h00);                  // R2 zero
        // directed corners
        run_vec(0, 8'h7F, 8'h01, 8'h00, 1'b0, 6'h00);                  // R2 V and H
        run_vec(0, 8'hFF, 8'h01, 8'h00, 1'b0, 6'h00);                  // R2 C and Z
        run_vec(1, 8'h0F, 8'h00, 8'h00, 1'b0, 6'h01);                  // R2 carry in
        run_vec(2, 8'h00, 8'h01, 8'h00, 1'b0, 6'h00);                  // R3 borrow
        run_vec(3, 8'h05, 8'h05, 8'h00, 1'b0, 6'h00);                  // R3 sticky Z stays 0
        run_vec(3, 8'h05, 8'h05, 8'h00, 1'b0, 6'h02);                  // R3 sticky Z kept
        run_vec(18, 8'h10, 8'h0F, 8'h00, 1'b0, 6'h03);                 // R10 CMPC zero
        run_vec(17, 8'h80, 8'h01, 8'h00, 1'b0, 6'h00);                 // R10 overflow
        run_vec(4, 8'hF0, 8'h55, 8'hAA, 1'b1, 6'h29);                  // R4 R12 immediate
        run_vec(7, 8'h00, 8'h00, 8'h00, 1'b0, 6'h20);                  // R5
        run_vec(8, 8'h80, 8'h00, 8'h00, 1'b0, 6'h00);                  // R6 0x80
        run_vec(8, 8'h00, 8'h00, 8'h00, 1'b0, 6'h3F);                  // R6 zero
        run_vec(9, 8'h7F, 8'h00, 8'h00, 1'b0, 6'h21);                  // R7
        run_vec(10, 8'h80, 8'h00, 8'h00, 1'b0, 6'h21);                 // R7
        run_vec(13, 8'h80, 8'h00, 8'h00, 1'b0, 6'h01);                 // R8 rotate
        run_vec(14, 8'h01, 8'h00, 8'h00, 1'b0, 6'h01);                 // R8 rotate
        run_vec(15, 8'h81, 8'h00, 8'h00, 1'b0, 6'h00);                 // R8 arithmetic
        run_vec(12, 8'h01, 8'h00, 8'h00, 1'b0, 6'h00);                 // R8 logical zero
        run_vec(16, 8'h3C, 8'h00, 8'h00, 1'b0, 6'h3F);                 // R9
        run_vec(31, 8'h12, 8'h34, 8'h00, 1'b0, 6'h15);                 // R13
        run_vec(19, 8'h00, 8'h00, 8'h00, 1'b0, 6'h2A);                 // R13
        // constrained random, R11 checked through every S-updating vector
        for (int i = 0; i < 4000; i++) begin
            int op;
            op = ($urandom % 8 == 0) ? int'($urandom % 32) : int'($urandom % 19);
            run_vec(op, int'($urandom % 256), int'($urandom % 256), int'($urandom % 256),
                    1'($urandom % 2), 6'($urandom % 64));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule